// File: doc/BRIEF.md
# Transmit FIFO Start Threshold Logic

This block decides when a transmitter may begin sending a frame that is still being loaded into its transmit FIFO. Software programs a start threshold over a small register bus. The block scales that value by four to get a byte count. It then watches the FIFO status inputs: the byte fill level, a full flag and a flag that marks a frame as completely written.

When any start condition holds and the transmitter is not halted, the block raises `tx_start` for exactly one cycle. It then stays quiet until the transmitter reports that the current frame is done. The threshold can only be changed while the transmitter is halted. Writes at other times are dropped. The FIFO itself is not part of the block: only its status inputs are seen.

Top module: `txs_start_top`

## Requirements
- R1: After reset the threshold field reads as zero and `tx_start` is low.
- R2: A read of the threshold register (address 0) returns the programmed field in bits 10..0, and bits 31..11 always read as zero.
- R3: A write to the threshold register takes effect only while `tx_halted` is high. A write while it is low leaves the stored field unchanged.
- R4: With the transmitter armed and not halted, `tx_start` rises when `fifo_level` is strictly greater than four times the field. A level equal to four times the field does not start.
- R5: `fifo_full` high starts transmission whatever the threshold is.
- R6: `frame_written` high starts transmission even when the level is below the threshold.
- R7: With a field of zero, any non-zero level starts transmission, and a level of zero does not.
- R8: `tx_start` is a one-cycle pulse, given once per frame. After a pulse, no further pulse appears until `tx_done` has been seen high on a clock edge. After that the block is armed again.
- R9: `tx_start` is never high while `tx_halted` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W (4) | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational, zero when not selected |
| fifo_level | input | LEVEL_W (14) | Bytes currently held in the transmit FIFO |
| fifo_full | input | 1 | Transmit FIFO is full |
| frame_written | input | 1 | A complete frame has been written into the FIFO |
| tx_halted | input | 1 | Transmitter is in the halted state |
| tx_done | input | 1 | Transmission of the current frame has finished |
| tx_start | output | 1 | One-cycle start-transmit pulse |

## Verification
The bench sets the fill level to exactly four times the field and then to one byte more. A design that used a non-strict compare, or forgot to scale by four, starts at the wrong level. It also leaves the start condition standing after a pulse. A design that does not wait for `tx_done` would pulse again at once or stay high. Writes while the transmitter is running are read back to show they were dropped, and a full FIFO is held while halted to show no start leaks through. A zero field with an empty FIFO checks that an empty FIFO never starts a frame.

// File: rtl/txs_pkg.sv
// Package: shared types and constants for the transmit start logic.
// Assumes: nothing; pure declarations.
package txs_pkg;

    // Arming state of the start sequencer
    typedef enum logic [0:0] {
        ST_ARMED = 1'b0,
        ST_WAIT  = 1'b1
    } arm_state_t;

    // Word address of the threshold register
    localparam int unsigned THR_REG_ADDR = 0;

endpackage

// File: rtl/txs_thresh_reg.sv
// Module: holds the programmable start threshold field and serves reads.
// Assumes: writes are only meaningful while the transmitter is halted;
// other writes are dropped. Reads are combinational and have no side effect.
module txs_thresh_reg #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned FIELD_W = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    input  logic               halted,
    output logic [DATA_W-1:0]  rdata,
    output logic [FIELD_W-1:0] field
);
    import txs_pkg::*;

    localparam int unsigned PAD_W = DATA_W - FIELD_W;

    logic sel;

    // Decode the register address
    assign sel = (addr == ADDR_W'(THR_REG_ADDR));

    // Store the field; accept writes only while halted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field <= '0;
        end else if (wr_en && sel && halted) begin
            field <= wdata[FIELD_W-1:0];
        end
    end

    // Return the field with the reserved upper bits forced to zero
    always_comb begin
        if (rd_en && sel) begin
            rdata = {{PAD_W{1'b0}}, field};
        end else begin
            rdata = '0;
        end
    end

endmodule

// File: rtl/txs_level_cmp.sv
// Module: forms the start condition from FIFO status and the threshold.
// Assumes: the byte threshold is four times the field; a level must exceed
// it strictly. Full and frame-written flags each bypass the threshold.
module txs_level_cmp #(
    parameter int unsigned FIELD_W = 11,
    parameter int unsigned LEVEL_W = 14
) (
    input  logic [FIELD_W-1:0] field,
    input  logic [LEVEL_W-1:0] level,
    input  logic               full,
    input  logic               frame_done_wr,
    output logic               cond
);
    localparam int unsigned THR_W = FIELD_W + 2;
    localparam int unsigned CMP_W = (THR_W > LEVEL_W) ? THR_W : LEVEL_W;

    logic [CMP_W-1:0] thr_bytes;
    logic [CMP_W-1:0] level_ext;
    logic             over;

    // Scale the field by four and extend both operands to a common width
    always_comb begin
        thr_bytes = CMP_W'({field, 2'b00});
        level_ext = CMP_W'(level);
    end

    // Strict comparison of level against the byte threshold
    assign over = (level_ext > thr_bytes);

    // Any of the three conditions allows a start
    assign cond = over | full | frame_done_wr;

endmodule

// File: rtl/txs_start_seq.sv
// Module: issues one start pulse per frame and re-arms on frame completion.
// Assumes: done is seen on a clock edge; the pulse is combinational from the
// armed state so that it can never appear while halted.
module txs_start_seq (
    input  logic clk,
    input  logic rst_n,
    input  logic cond,
    input  logic halted,
    input  logic done,
    output logic start
);
    import txs_pkg::*;

    arm_state_t state_q;
    arm_state_t state_d;

    // Pulse while armed, running and a condition holds
    assign start = (state_q == ST_ARMED) && !halted && cond;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARMED: if (start) state_d = ST_WAIT;
            ST_WAIT:  if (done)  state_d = ST_ARMED;
            default:  state_d = ST_ARMED;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
        end else begin
            state_q <= state_d;
        end
    end

endmodule

// File: rtl/txs_start_top.sv
// Module: top of the transmit FIFO start threshold logic.
// Assumes: the FIFO is represented only by its status inputs; the register
// bus is single-cycle with combinational read data.
module txs_start_top #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned DATA_W  = 32,
    parameter int unsigned FIELD_W = 11,
    parameter int unsigned LEVEL_W = 14
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wr_en,
    input  logic               reg_rd_en,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [DATA_W-1:0]  reg_wdata,
    output logic [DATA_W-1:0]  reg_rdata,
    input  logic [LEVEL_W-1:0] fifo_level,
    input  logic               fifo_full,
    input  logic               frame_written,
    input  logic               tx_halted,
    input  logic               tx_done,
    output logic               tx_start
);
    logic [FIELD_W-1:0] thr_field;
    logic               start_cond;

    txs_thresh_reg #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .FIELD_W (FIELD_W)
    ) u_reg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .rd_en  (reg_rd_en),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .halted (tx_halted),
        .rdata  (reg_rdata),
        .field  (thr_field)
    );

    txs_level_cmp #(
        .FIELD_W (FIELD_W),
        .LEVEL_W (LEVEL_W)
    ) u_cmp (
        .field         (thr_field),
        .level         (fifo_level),
        .full          (fifo_full),
        .frame_done_wr (frame_written),
        .cond          (start_cond)
    );

    txs_start_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .cond   (start_cond),
        .halted (tx_halted),
        .done   (tx_done),
        .start  (tx_start)
    );

endmodule

// File: rtl/txs_start_chk.sv
// Module: property checker bound to txs_start_top.
// Assumes: it observes the ports and the stored field; it keeps its own
// record of an outstanding frame.
module txs_start_chk #(
    parameter int unsigned ADDR_W  = 4,
    parameter int unsigned FIELD_W = 11,
    parameter int unsigned LEVEL_W = 14
) (
    input logic               clk,
    input logic               rst_n,
    input logic               reg_wr_en,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [LEVEL_W-1:0] fifo_level,
    input logic               fifo_full,
    input logic               tx_halted,
    input logic               tx_done,
    input logic               tx_start,
    input logic [FIELD_W-1:0] thr_field
);
    logic pending;

    // Track a frame that has been started but not yet reported done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending <= 1'b0;
        end else if (tx_start) begin
            pending <= 1'b1;
        end else if (tx_done) begin
            pending <= 1'b0;
        end
    end

    // R9
    halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |-> !tx_halted);

    // R8
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);

    // R8
    once_per_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pending |-> !tx_start);

    // R3
    write_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == '0 && !tx_halted) |=> $stable(thr_field));

    // R4
    level_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_halted && !pending &&
         ({2'b00, fifo_level} > {{(LEVEL_W + 2 - FIELD_W){1'b0}}, thr_field, 2'b00}))
        |-> tx_start);

    // R5
    full_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_halted && !pending && fifo_full) |-> tx_start);

endmodule

bind txs_start_top txs_start_chk #(
    .ADDR_W  (ADDR_W),
    .FIELD_W (FIELD_W),
    .LEVEL_W (LEVEL_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr_en  (reg_wr_en),
    .reg_addr   (reg_addr),
    .fifo_level (fifo_level),
    .fifo_full  (fifo_full),
    .tx_halted  (tx_halted),
    .tx_done    (tx_done),
    .tx_start   (tx_start),
    .thr_field  (thr_field)
);

// File: tb/txs_start_top_test.sv
// Directed bench for txs_start_top: one task per scenario.
module txs_start_top_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr_en;
    logic        reg_rd_en;
    logic [3:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [13:0] fifo_level;
    logic        fifo_full;
    logic        frame_written;
    logic        tx_halted;
    logic        tx_done;
    logic        tx_start;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    txs_start_top uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .reg_wr_en     (reg_wr_en),
        .reg_rd_en     (reg_rd_en),
        .reg_addr      (reg_addr),
        .reg_wdata     (reg_wdata),
        .reg_rdata     (reg_rdata),
        .fifo_level    (fifo_level),
        .fifo_full     (fifo_full),
        .frame_written (frame_written),
        .tx_halted     (tx_halted),
        .tx_done       (tx_done),
        .tx_start      (tx_start)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_thr(input logic [31:0] val);
        @(negedge clk);
        reg_addr  = 4'd0;
        reg_wdata = val;
        reg_wr_en = 1'b1;
        @(negedge clk);
        reg_wr_en = 1'b0;
    endtask

    task automatic read_thr(output logic [31:0] val);
        @(negedge clk);
        reg_addr  = 4'd0;
        reg_rd_en = 1'b1;
        #1 val = reg_rdata;
        reg_rd_en = 1'b0;
    endtask

    // Clear FIFO status and report the frame done for one edge
    task automatic close_frame();
        @(negedge clk);
        fifo_level    = '0;
        fifo_full     = 1'b0;
        frame_written = 1'b0;
        tx_done       = 1'b1;
        @(negedge clk);
        tx_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst_n = 1'b0; reg_wr_en = 0; reg_rd_en = 0; reg_addr = 0; reg_wdata = 0;
        fifo_level = 0; fifo_full = 0; frame_written = 0; tx_halted = 1; tx_done = 0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1 check("R1 start after reset", {31'd0, tx_start}, 32'd0);
        read_thr(v);
        check("R1 field after reset", v, 32'd0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        tx_halted = 1'b1;
        write_thr(32'hFFFF_FFFF);
        read_thr(v);
        check("R2 reserved bits zero", v, 32'h0000_07FF);
        write_thr(32'd5);
        read_thr(v);
        check("R2 field readback", v, 32'd5);
    endtask

    task automatic t_write_running();
        logic [31:0] v;
        @(negedge clk) tx_halted = 1'b0;
        write_thr(32'd9);
        @(negedge clk) tx_halted = 1'b1;
        read_thr(v);
        check("R3 write while running dropped", v, 32'd5);
    endtask

    task automatic t_threshold();
        @(negedge clk);
        tx_halted  = 1'b0;
        fifo_level = 14'd20;
        #1 check("R4 level equal to 4x field", {31'd0, tx_start}, 32'd0);
        @(negedge clk) fifo_level = 14'd21;
        #1 check("R4 level above 4x field", {31'd0, tx_start}, 32'd1);
        @(posedge clk); #1;
        check("R8 pulse lasts one cycle", {31'd0, tx_start}, 32'd0);
        @(posedge clk); #1;
        check("R8 no second pulse before done", {31'd0, tx_start}, 32'd0);
        @(negedge clk) tx_done = 1'b1;
        @(negedge clk) tx_done = 1'b0;
        #1 check("R8 re-armed after done", {31'd0, tx_start}, 32'd1);
        close_frame();
    endtask

    task automatic t_full();
        @(negedge clk);
        fifo_level = 14'd3;
        fifo_full  = 1'b1;
        #1 check("R5 full forces start", {31'd0, tx_start}, 32'd1);
        close_frame();
    endtask

    task automatic t_frame_written();
        @(negedge clk);
        fifo_level    = 14'd1;
        frame_written = 1'b1;
        #1 check("R6 frame written forces start", {31'd0, tx_start}, 32'd1);
        close_frame();
    endtask

    task automatic t_zero();
        @(negedge clk) tx_halted = 1'b1;
        write_thr(32'd0);
        @(negedge clk);
        tx_halted  = 1'b0;
        fifo_level = 14'd0;
        #1 check("R7 empty fifo with zero field", {31'd0, tx_start}, 32'd0);
        @(negedge clk) fifo_level = 14'd1;
        #1 check("R7 one byte with zero field", {31'd0, tx_start}, 32'd1);
        close_frame();
    endtask

    task automatic t_halted();
        @(negedge clk);
        tx_halted  = 1'b1;
        fifo_level = 14'd100;
        fifo_full  = 1'b1;
        #1 check("R9 no start while halted", {31'd0, tx_start}, 32'd0);
        @(posedge clk); #1;
        check("R9 still no start while halted", {31'd0, tx_start}, 32'd0);
        @(negedge clk) tx_halted = 1'b0;
        #1 check("R9 start once released", {31'd0, tx_start}, 32'd1);
        close_frame();
    endtask

    initial begin
        t_reset();
        t_regs();
        t_write_running();
        t_threshold();
        t_full();
        t_frame_written();
        t_zero();
        t_halted();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule